// File: doc/BRIEF.md
# Packed-SIMD Fault Gate

This block sits in the issue stage of a simple processor model and screens every issued instruction before it runs. For floating-point, packed-SIMD and multimedia instructions it checks the emulation and task-switched control bits and any floating-point error left pending. For every instruction that touches memory it checks the operand against the segment bounds, the translation result and the alignment rule. When any check fails, one fault is reported with a single vector chosen by fixed priority.

The task-switched flag is kept inside the block. A task-switch event sets it, and it stays set. The next floating-point or SIMD-type instruction then traps, so that a handler can save the register state lazily and afterwards drop the flag with a clear command. The flag is exported so that the rest of the control-register file can read it.

Top module: `simd_fault_gate`

## Requirements
- R1: While reset is low and on the first cycle after it, `fault_valid` is 0, `fault_vec` is 0 and `ts_flag` is 0.
- R2: A cycle with `task_switch` high makes `ts_flag` 1 from the next cycle on. This holds even when `clear_ts` is high in the same cycle. With neither input high, `ts_flag` holds its value.
- R3: A cycle with `clear_ts` high and `task_switch` low makes `ts_flag` 0 from the next cycle. Later SIMD-type instructions then issue with no fault.
- R4: With `cr_em` 1, an issued instruction of class 2 (packed-SIMD) or class 3 (multimedia) faults with vector 6. `cr_em` has no effect on class 1 (floating-point) or class 0 (other).
- R5: With `ts_flag` 1, an issued instruction of class 1, 2 or 3 faults with vector 7.
- R6: With `fp_err_pending` 1, an issued instruction of class 1, 2 or 3 faults with vector 16.
- R7: In real mode (`cpu_mode` 0), a memory operand whose last byte (`op_addr` + 2^`op_size_log2` − 1) is above 0xFFFF faults with vector 13. An operand ending at exactly 0xFFFF does not fault.
- R8: In protected (`cpu_mode` 1, or the reserved code 3) or virtual-8086 mode (`cpu_mode` 2), an operand whose last byte is above `seg_limit` faults with vector 12 when `stack_seg` is 1 and with vector 13 otherwise. An operand with `seg_legal` 0 faults with vector 13.
- R9: `xlate_fault` on a memory operand faults with vector 14 outside real mode. In real mode it has no effect.
- R10: A memory operand whose address is not a multiple of its size faults with vector 17 only when `cr_am` is 1, `cpl` is 3 and the mode is not real.
- R11: A class 0 instruction never faults on `cr_em`, `ts_flag` or `fp_err_pending`.
- R12: `fault_valid` is high for exactly the one cycle after an issue cycle whose instruction faults. `fault_vec` changes only together with a new fault and otherwise holds its last value.
- R13: When several checks fail for one instruction, only one vector is reported, chosen in the order 6, 7, 16, 12, 13, 14, 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_em | input | 1 | Emulation control bit |
| cr_am | input | 1 | Alignment-mask control bit |
| task_switch | input | 1 | Task-switch event, sets the flag |
| clear_ts | input | 1 | Command to clear the flag |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 treated as protected |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_class | input | 2 | 0 other, 1 floating-point, 2 packed-SIMD, 3 multimedia |
| mem_access | input | 1 | Instruction has a memory operand |
| op_addr | input | ADDR_W | Operand effective address |
| op_size_log2 | input | 2 | Operand size as log2 of bytes (1 to 8) |
| seg_limit | input | ADDR_W | Highest valid offset in the operand segment |
| seg_legal | input | 1 | Segment permits this access |
| stack_seg | input | 1 | Operand uses the stack segment |
| xlate_fault | input | 1 | Address translation failed |
| fp_err_pending | input | 1 | Unmasked floating-point error pending |
| ts_flag | output | 1 | Current task-switched flag |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_vec | output | 8 | Vector of the reported fault |

## Verification
The assertions assume that the operand, mode and control inputs are steady and meaningful in every cycle where `issue_valid` is high. Outside such cycles they are ignored. They also assume that `cpl` and `cpu_mode` go together, with virtual-8086 running at level 3. The stimulus changes these inputs only on the falling edge, raises `issue_valid` for a single cycle per instruction, and sets up each mode and privilege pair before it issues.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_RSVD = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_FLOAT  = 2'd1,
        CLS_PACKED = 2'd2,
        CLS_MEDIA  = 2'd3
    } insn_class_e;

    localparam int unsigned VEC_W = 8;

    localparam logic [VEC_W-1:0] VEC_INVALID_OP = 8'd6;
    localparam logic [VEC_W-1:0] VEC_NO_DEVICE  = 8'd7;
    localparam logic [VEC_W-1:0] VEC_STACK      = 8'd12;
    localparam logic [VEC_W-1:0] VEC_PROTECT    = 8'd13;
    localparam logic [VEC_W-1:0] VEC_PAGE       = 8'd14;
    localparam logic [VEC_W-1:0] VEC_FPU_ERR    = 8'd16;
    localparam logic [VEC_W-1:0] VEC_ALIGN      = 8'd17;

    // Memory-side check results for one instruction
    typedef struct packed {
        logic stack_hit;
        logic prot_hit;
        logic page_hit;
        logic align_hit;
    } mem_flags_t;

    // Registered fault report
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } fault_rep_t;

endpackage

// File: rtl/sfg_switch_flag.sv
module sfg_switch_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic task_switch,
    input  logic clear_ts,
    output logic ts_o
);

    typedef struct packed {
        logic ts;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // A switch event outranks a clear in the same cycle
    always_comb begin
        st_d = st_q;
        if (clear_ts)    st_d.ts = 1'b0;
        if (task_switch) st_d.ts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts_o = st_q.ts;

    assert_ts_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> ts_o);

    assert_ts_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!task_switch && !clear_ts) |=> $stable(ts_o));

    assert_ts_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_ts && !task_switch) |=> !ts_o);

endmodule

// File: rtl/sfg_operand_check.sv
module sfg_operand_check
    import sfg_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] REAL_TOP = 'h0FFFF
) (
    input  cpu_mode_e         mode,
    input  logic              mem_access,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [1:0]        op_size_log2,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              seg_legal,
    input  logic              stack_seg,
    input  logic              xlate_fault,
    input  logic              cr_am,
    input  logic [1:0]        cpl,
    output mem_flags_t        flags
);

    localparam int unsigned EXT_W     = ADDR_W + 1;
    localparam int unsigned ALIGN_BITS = 3;

    logic              real_mode;
    logic [EXT_W-1:0]  span_m1;
    logic [EXT_W-1:0]  last_byte;
    logic [EXT_W-1:0]  bound;
    logic              over_bound;
    logic [ALIGN_BITS-1:0] low_mask;
    logic              misaligned;
    logic              user_level;

    assign real_mode  = (mode == MODE_REAL);
    assign user_level = (cpl == 2'd3);

    always_comb begin
        span_m1 = '0;
        unique case (op_size_log2)
            2'd0: span_m1[2:0] = 3'd0;
            2'd1: span_m1[2:0] = 3'd1;
            2'd2: span_m1[2:0] = 3'd3;
            default: span_m1[2:0] = 3'd7;
        endcase
    end

    assign last_byte  = {1'b0, op_addr} + span_m1;
    assign bound      = real_mode ? {1'b0, REAL_TOP} : {1'b0, seg_limit};
    assign over_bound = (last_byte > bound);

    // Address bit b must be zero when the operand spans more than 2^b bytes
    for (genvar b = 0; b < ALIGN_BITS; b++) begin : g_align_mask
        assign low_mask[b] = (int'(op_size_log2) > b);
    end

    assign misaligned = |(op_addr[ALIGN_BITS-1:0] & low_mask);

    always_comb begin
        flags = '0;
        if (mem_access) begin
            if (real_mode) begin
                flags.prot_hit = over_bound;
            end else begin
                flags.stack_hit = stack_seg && over_bound;
                flags.prot_hit  = (!stack_seg && over_bound) || !seg_legal;
                flags.page_hit  = xlate_fault;
                flags.align_hit = cr_am && user_level && misaligned;
            end
        end
    end

endmodule

// File: rtl/sfg_fault_select.sv
module sfg_fault_select
    import sfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  insn_class_e      iclass,
    input  logic             cr_em,
    input  logic             ts,
    input  logic             fp_err,
    input  mem_flags_t       flags,
    output logic             fault_valid,
    output logic [VEC_W-1:0] fault_vec
);

    fault_rep_t rep_d, rep_q;

    logic media_cls;
    logic fpu_cls;

    assign media_cls = (iclass == CLS_PACKED) || (iclass == CLS_MEDIA);
    assign fpu_cls   = media_cls || (iclass == CLS_FLOAT);

    always_comb begin
        rep_d       = rep_q;
        rep_d.valid = 1'b0;
        if (issue_valid) begin
            rep_d.valid = 1'b1;
            if (media_cls && cr_em)      rep_d.vec = VEC_INVALID_OP;
            else if (fpu_cls && ts)      rep_d.vec = VEC_NO_DEVICE;
            else if (fpu_cls && fp_err)  rep_d.vec = VEC_FPU_ERR;
            else if (flags.stack_hit)    rep_d.vec = VEC_STACK;
            else if (flags.prot_hit)     rep_d.vec = VEC_PROTECT;
            else if (flags.page_hit)     rep_d.vec = VEC_PAGE;
            else if (flags.align_hit)    rep_d.vec = VEC_ALIGN;
            else                         rep_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign fault_valid = rep_q.valid;
    assign fault_vec   = rep_q.vec;

    assert_em_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && media_cls && cr_em)
        |=> (fault_valid && fault_vec == VEC_INVALID_OP));

    assert_ts_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && fpu_cls && ts && !(media_cls && cr_em))
        |=> (fault_valid && fault_vec == VEC_NO_DEVICE));

    assert_fp_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && fpu_cls && fp_err && !ts && !(media_cls && cr_em))
        |=> (fault_valid && fault_vec == VEC_FPU_ERR));

    assert_other_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && iclass == CLS_OTHER && flags == '0) |=> !fault_valid);

    assert_strobe_only_after_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !fault_valid);

    assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |-> $stable(fault_vec));

    assert_page_over_align_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && iclass == CLS_OTHER && flags.page_hit && !flags.stack_hit
         && !flags.prot_hit) |=> (fault_valid && fault_vec == VEC_PAGE));

endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
    import sfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_em,
    input  logic              cr_am,
    input  logic              task_switch,
    input  logic              clear_ts,
    input  logic [1:0]        cpl,
    input  logic [1:0]        cpu_mode,
    input  logic              issue_valid,
    input  logic [1:0]        issue_class,
    input  logic              mem_access,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [1:0]        op_size_log2,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              seg_legal,
    input  logic              stack_seg,
    input  logic              xlate_fault,
    input  logic              fp_err_pending,
    output logic              ts_flag,
    output logic              fault_valid,
    output logic [7:0]        fault_vec
);

    localparam logic [ADDR_W-1:0] REAL_TOP = ADDR_W'('h0FFFF);

    mem_flags_t  mem_flags;
    logic        ts_now;
    cpu_mode_e   mode_e;
    insn_class_e class_e;

    assign mode_e  = cpu_mode_e'(cpu_mode);
    assign class_e = insn_class_e'(issue_class);

    sfg_switch_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .task_switch (task_switch),
        .clear_ts    (clear_ts),
        .ts_o        (ts_now)
    );

    sfg_operand_check #(
        .ADDR_W   (ADDR_W),
        .REAL_TOP (REAL_TOP)
    ) u_operand (
        .mode         (mode_e),
        .mem_access   (mem_access),
        .op_addr      (op_addr),
        .op_size_log2 (op_size_log2),
        .seg_limit    (seg_limit),
        .seg_legal    (seg_legal),
        .stack_seg    (stack_seg),
        .xlate_fault  (xlate_fault),
        .cr_am        (cr_am),
        .cpl          (cpl),
        .flags        (mem_flags)
    );

    sfg_fault_select u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .iclass      (class_e),
        .cr_em       (cr_em),
        .ts          (ts_now),
        .fp_err      (fp_err_pending),
        .flags       (mem_flags),
        .fault_valid (fault_valid),
        .fault_vec   (fault_vec)
    );

    assign ts_flag = ts_now;

    assert_real_no_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && mode_e == MODE_REAL && class_e == CLS_OTHER && mem_access
         && op_addr <= ADDR_W'('h0FFF0)) |=> !fault_valid);

    assert_no_align_kernel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cpl != 2'd3) |=> !(fault_valid && fault_vec == VEC_ALIGN));

endmodule

// File: tb/test_simd_fault_gate.sv
module test_simd_fault_gate;

    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cr_em, cr_am, task_switch, clear_ts;
    logic [1:0]        cpl, cpu_mode, issue_class, op_size_log2;
    logic              issue_valid, mem_access, seg_legal, stack_seg, xlate_fault, fp_err_pending;
    logic [ADDR_W-1:0] op_addr, seg_limit;
    logic              ts_flag, fault_valid;
    logic [7:0]        fault_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    simd_fault_gate #(.ADDR_W(ADDR_W)) i_simd_fault_gate (
        .clk(clk), .rst_n(rst_n), .cr_em(cr_em), .cr_am(cr_am),
        .task_switch(task_switch), .clear_ts(clear_ts), .cpl(cpl), .cpu_mode(cpu_mode),
        .issue_valid(issue_valid), .issue_class(issue_class), .mem_access(mem_access),
        .op_addr(op_addr), .op_size_log2(op_size_log2), .seg_limit(seg_limit),
        .seg_legal(seg_legal), .stack_seg(stack_seg), .xlate_fault(xlate_fault),
        .fp_err_pending(fp_err_pending), .ts_flag(ts_flag), .fault_valid(fault_valid),
        .fault_vec(fault_vec)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic defaults();
        cr_em = 0; cr_am = 0; task_switch = 0; clear_ts = 0;
        cpl = 0; cpu_mode = 2'd1; issue_valid = 0; issue_class = 2'd0;
        mem_access = 0; op_addr = 32'h1000; op_size_log2 = 0;
        seg_limit = 32'hFFFF_FFFF; seg_legal = 1; stack_seg = 0;
        xlate_fault = 0; fp_err_pending = 0;
    endtask

    // Issue one instruction; expv 0 means no fault expected
    task automatic issue(input string req, input int expv);
        @(negedge clk);
        issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
        check({req, " valid"}, int'(fault_valid), int'(expv != 0));
        if (expv != 0) check({req, " vector"}, int'(fault_vec), expv);
    endtask

    task automatic pulse(input bit sw, input bit clr);
        @(negedge clk);
        task_switch = sw; clear_ts = clr;
        @(negedge clk);
        task_switch = 0; clear_ts = 0;
    endtask

    task automatic t_reset();
        check("R1 fault_valid", int'(fault_valid), 0);
        check("R1 fault_vec", int'(fault_vec), 0);
        check("R1 ts_flag", int'(ts_flag), 0);
    endtask

    task automatic t_em();
        defaults(); cr_em = 1;
        issue_class = 2'd2; issue("R4 packed em", 6);
        issue_class = 2'd3; issue("R4 media em", 6);
        issue_class = 2'd1; issue("R4 float ignores em", 0);
        issue_class = 2'd0; issue("R11 other ignores em", 0);
    endtask

    task automatic t_ts();
        defaults();
        pulse(1, 0);
        check("R2 ts set", int'(ts_flag), 1);
        issue_class = 2'd1; issue("R5 float with ts", 7);
        issue_class = 2'd2; issue("R5 packed with ts", 7);
        issue_class = 2'd0; issue("R11 other ignores ts", 0);
        check("R2 ts sticky", int'(ts_flag), 1);
        cr_em = 1; issue_class = 2'd2; issue("R13 em over ts", 6);
        cr_em = 0;
        pulse(0, 1);
        check("R3 ts cleared", int'(ts_flag), 0);
        issue_class = 2'd2; issue("R3 packed after clear", 0);
        pulse(1, 1);
        check("R2 set wins over clear", int'(ts_flag), 1);
        pulse(0, 1);
        check("R3 ts cleared again", int'(ts_flag), 0);
    endtask

    task automatic t_fperr();
        defaults(); fp_err_pending = 1;
        issue_class = 2'd1; issue("R6 float pending err", 16);
        issue_class = 2'd3; issue("R6 media pending err", 16);
        issue_class = 2'd0; issue("R11 other ignores pending err", 0);
        pulse(1, 0);
        issue_class = 2'd1; issue("R13 ts over pending err", 7);
        pulse(0, 1);
        issue_class = 2'd1; mem_access = 1; stack_seg = 1;
        seg_limit = 32'h10; op_addr = 32'h20;
        issue("R13 pending err over stack", 16);
    endtask

    task automatic t_real();
        defaults(); cpu_mode = 2'd0; mem_access = 1; op_size_log2 = 2;
        op_addr = 32'hFFFC; issue("R7 ends at 0xFFFF", 0);
        op_addr = 32'hFFFD; issue("R7 crosses 0xFFFF", 13);
        op_size_log2 = 0; op_addr = 32'hFFFF; issue("R7 single byte at top", 0);
        op_addr = 32'h0100; xlate_fault = 1; issue("R9 real ignores page fault", 0);
        xlate_fault = 0; cr_am = 1; cpl = 3; op_size_log2 = 2; op_addr = 32'h0102;
        issue("R10 real ignores alignment", 0);
    endtask

    task automatic t_seg();
        defaults(); mem_access = 1; op_addr = 32'h100; op_size_log2 = 3;
        seg_limit = 32'h107; issue("R8 ends at limit", 0);
        seg_limit = 32'h106; stack_seg = 1; issue("R8 stack over limit", 12);
        stack_seg = 0; issue("R8 data over limit", 13);
        seg_limit = 32'h1000; seg_legal = 0; issue("R8 illegal segment", 13);
        seg_legal = 1; cpu_mode = 2'd2; cpl = 3; seg_limit = 32'h106; stack_seg = 1;
        issue("R8 v86 stack over limit", 12);
    endtask

    task automatic t_page();
        defaults(); mem_access = 1; xlate_fault = 1;
        issue("R9 page fault", 14);
        cr_am = 1; cpl = 3; op_size_log2 = 2; op_addr = 32'h1002;
        issue("R13 page over alignment", 14);
        seg_limit = 32'h1001; issue("R13 segment over page", 13);
    endtask

    task automatic t_align();
        defaults(); mem_access = 1; cr_am = 1; cpl = 3; op_size_log2 = 2;
        op_addr = 32'h1002; issue("R10 misaligned user", 17);
        cpl = 0; issue("R10 kernel level", 0);
        cpl = 3; cr_am = 0; issue("R10 mask off", 0);
        cr_am = 1; op_addr = 32'h1004; issue("R10 aligned", 0);
        op_size_log2 = 1; op_addr = 32'h1001; cpu_mode = 2'd2; issue("R10 v86 misaligned", 17);
    endtask

    task automatic t_strobe();
        defaults(); cr_em = 1; issue_class = 2'd2;
        issue("R12 fault", 6);
        @(negedge clk);
        check("R12 strobe one cycle", int'(fault_valid), 0);
        check("R12 vector held", int'(fault_vec), 6);
        cr_em = 0; issue("R12 clean issue", 0);
        check("R12 vector held after clean", int'(fault_vec), 6);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_em();
        t_ts();
        t_fperr();
        t_real();
        t_seg();
        t_page();
        t_align();
        t_strobe();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule